// File: doc/BRIEF.md
# Video line-rate doubler with two-line interpolation

This block turns an interlaced 4:2:2 video line stream into a stream with twice as many lines. Each word carries a luma byte and a chroma byte. Even positions in a line hold Cb and odd positions hold Cr. Input samples arrive on alternate cycles of the block clock, which is the output clock. Each output line is emitted at one sample per cycle, so it takes half the input line period. Every input line period therefore yields two output lines.

The first output line of a period repeats the previous source line unchanged. The second is a new line whose samples are the rounded mean of the previous line and the line now arriving, taken position by position. Two internal line banks alternate roles: one is written while the other is read. The active width is chosen per line from three parameterised sizes. No line is averaged across a field boundary.

After reset, output stays silent until the second field marker, because the first field only fills the line banks. An output-enable pin can blank the data without stopping the timing signals.

Top module: `line_doubler_interp`

## Requirements
- R1: Each line marker (`in_valid` and `in_line_start` both high) opens an output period. The first output sample becomes visible one cycle after the edge that accepts the marker. Output samples then follow on consecutive cycles: 2W of them, or W in a field-opening period, where W is the width latched at that marker.
- R2: The first W samples of a period carry, unchanged, the line that was stored before the marker. Sample j is word j of that line.
- R3: In a period that does not open a field, output samples W..2W-1 are averages. For position j the luma byte (bits 15:8) equals (a+b+1)>>1, where a is the luma of word j of the previous line and b is the luma of word j of the line now arriving.
- R4: The chroma byte (bits 7:0) of an averaged sample uses the same rounding, applied to the chroma bytes at the same position in the two lines. Both lines start with Cb, so Cb is only averaged with Cb and Cr only with Cr.
- R5: Width select decodes as follows: 0 gives the narrow width when `cfg_lines_525` is 1 and the middle width otherwise; 1 gives the middle width; 2 and 3 give the wide width. The width is sampled with each line marker.
- R6: A marker that also carries `in_field_start` opens a period with only the W samples of the stored line and no averaged line.
- R7: `out_valid` stays low until the second field marker after reset has been accepted.
- R8: While `oe` is low in the cycle before an output sample, that sample's data is zero. `out_valid` and `out_line_start` keep their timing.
- R9: In reset, and in the cycle after it, `out_valid`, `out_line_start` and `out_data` are zero.
- R10: `out_line_start` is high exactly on the first sample of each output line (offsets 0 and W of a period) and never without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (output sample rate) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width_sel | input | 2 | Active width select |
| cfg_lines_525 | input | 1 | 1 when the 525-line standard is in use (permits the narrow width) |
| oe | input | 1 | Output data enable; 0 forces data to zero |
| in_valid | input | 1 | Input sample strobe, on alternate cycles |
| in_line_start | input | 1 | Marks the first sample of a line |
| in_field_start | input | 1 | Marks the first line of a field (together with the line marker) |
| in_data | input | 16 | Luma in 15:8, multiplexed Cb/Cr in 7:0 |
| out_valid | output | 1 | Output sample valid |
| out_line_start | output | 1 | First sample of an output line |
| out_data | output | 16 | Luma in 15:8, chroma in 7:0 |

## Verification
A wrong bank selection or a bad write pointer shows in the averaged half of a period. The sample at the affected position mixes in a word from two lines back, and this is visible within W cycles of the marker. A wrong period counter or width latch moves or drops `out_valid` samples, which a cycle-stamped comparison catches on the first misplaced sample. Errors in the arming or field-opening logic show as output before the second field or as an averaged line straddling two fields. Either appears in the first period that follows the marker.

// File: rtl/ldi_pkg.sv
package ldi_pkg;

    typedef struct packed {
        logic [7:0] luma;
        logic [7:0] chroma;
    } pix_t;

    typedef enum logic [1:0] {
        ARM_NONE  = 2'd0,
        ARM_ONE   = 2'd1,
        ARM_READY = 2'd2
    } arm_e;

    typedef enum logic [1:0] {
        WSEL_NARROW = 2'd0,
        WSEL_MID    = 2'd1,
        WSEL_WIDE   = 2'd2,
        WSEL_WIDE2  = 2'd3
    } wsel_e;

    function automatic logic [7:0] mean_u8(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b} + 9'd1;
        return s[8:1];
    endfunction

    function automatic pix_t mean_pix(input pix_t a, input pix_t b);
        pix_t r;
        r.luma   = mean_u8(a.luma, b.luma);
        r.chroma = mean_u8(a.chroma, b.chroma);
        return r;
    endfunction

endpackage

// File: rtl/ldi_line_store.sv
module ldi_line_store
    import ldi_pkg::*;
#(
    parameter int DEPTH = 768,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [AW-1:0]    wr_addr,
    input  pix_t             wr_data,
    input  logic [AW-1:0]    rd_addr,
    output pix_t [1:0]       rd_data
);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        pix_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign rd_data[b] = mem[rd_addr];
    end

endmodule

// File: rtl/ldi_seq.sv
module ldi_seq
    import ldi_pkg::*;
#(
    parameter int AW = 10,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_line_start,
    input  logic          in_field_start,
    input  logic [CW-1:0] width,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic          rd_avg,
    output logic          rd_first,
    output logic          new_bank
);

    logic          ls, fs;
    logic          bank_q, have_line, act, single;
    logic [CW-1:0] wcnt, cnt, line_w, last_cnt;
    logic          store_more;
    arm_e          arm_q;

    assign ls         = in_valid & in_line_start;
    assign fs         = ls & in_field_start;
    assign store_more = in_valid & have_line & (wcnt < line_w);
    assign last_cnt   = single ? (line_w - CW'(1)) : ((line_w << 1) - CW'(1));

    assign wr_en    = ls | store_more;
    assign wr_bank  = ls ? ~bank_q : bank_q;
    assign wr_addr  = ls ? '0 : AW'(wcnt);

    assign rd_avg   = (cnt >= line_w);
    assign rd_addr  = rd_avg ? AW'(cnt - line_w) : AW'(cnt);
    assign rd_valid = act & (arm_q == ARM_READY);
    assign rd_first = (cnt == '0) | (cnt == line_w);
    assign new_bank = bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q    <= 1'b0;
            have_line <= 1'b0;
            act       <= 1'b0;
            single    <= 1'b0;
            wcnt      <= '0;
            cnt       <= '0;
            line_w    <= '0;
            arm_q     <= ARM_NONE;
        end else if (ls) begin
            bank_q    <= ~bank_q;
            have_line <= 1'b1;
            wcnt      <= CW'(1);
            line_w    <= width;
            act       <= 1'b1;
            cnt       <= '0;
            single    <= fs;
            if (fs) begin
                case (arm_q)
                    ARM_NONE: arm_q <= ARM_ONE;
                    ARM_ONE:  arm_q <= ARM_READY;
                    default:  arm_q <= ARM_READY;
                endcase
            end
        end else begin
            if (store_more) begin
                wcnt <= wcnt + CW'(1);
            end
            if (act) begin
                if (cnt == last_cnt) begin
                    act <= 1'b0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/ldi_out.sv
module ldi_out
    import ldi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        oe,
    input  logic        rd_valid,
    input  logic        rd_avg,
    input  logic        rd_first,
    input  pix_t        older,
    input  pix_t        newer,
    output logic        out_valid,
    output logic        out_line_start,
    output logic [15:0] out_data
);

    pix_t pick;

    always_comb begin
        pick = rd_avg ? mean_pix(older, newer) : older;
        if (!(rd_valid && oe)) begin
            pick = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_line_start <= 1'b0;
            out_data       <= '0;
        end else begin
            out_valid      <= rd_valid;
            out_line_start <= rd_valid & rd_first;
            out_data       <= pick;
        end
    end

endmodule

// File: rtl/line_doubler_interp.sv
module line_doubler_interp
    import ldi_pkg::*;
#(
    parameter int W_NARROW = 640,
    parameter int W_MID    = 720,
    parameter int W_WIDE   = 768
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_width_sel,
    input  logic        cfg_lines_525,
    input  logic        oe,
    input  logic        in_valid,
    input  logic        in_line_start,
    input  logic        in_field_start,
    input  logic [15:0] in_data,
    output logic        out_valid,
    output logic        out_line_start,
    output logic [15:0] out_data
);

    localparam int AW = (W_WIDE > 1) ? $clog2(W_WIDE) : 1;
    localparam int CW = $clog2(2 * W_WIDE + 1);

    logic [CW-1:0] sel_width;
    logic          wr_en, wr_bank, rd_valid, rd_avg, rd_first, new_bank;
    logic [AW-1:0] wr_addr, rd_addr;
    pix_t [1:0]    rd_data;
    pix_t          older, newer;

    always_comb begin
        case (wsel_e'(cfg_width_sel))
            WSEL_NARROW: sel_width = cfg_lines_525 ? CW'(W_NARROW) : CW'(W_MID);
            WSEL_MID:    sel_width = CW'(W_MID);
            default:     sel_width = CW'(W_WIDE);
        endcase
    end

    ldi_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_line_start  (in_line_start),
        .in_field_start (in_field_start),
        .width          (sel_width),
        .wr_en          (wr_en),
        .wr_bank        (wr_bank),
        .wr_addr        (wr_addr),
        .rd_addr        (rd_addr),
        .rd_valid       (rd_valid),
        .rd_avg         (rd_avg),
        .rd_first       (rd_first),
        .new_bank       (new_bank)
    );

    ldi_line_store #(.DEPTH(W_WIDE), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (pix_t'(in_data)),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign older = rd_data[~new_bank];
    assign newer = rd_data[new_bank];

    ldi_out u_out (
        .clk            (clk),
        .rst            (rst),
        .oe             (oe),
        .rd_valid       (rd_valid),
        .rd_avg         (rd_avg),
        .rd_first       (rd_first),
        .older          (older),
        .newer          (newer),
        .out_valid      (out_valid),
        .out_line_start (out_line_start),
        .out_data       (out_data)
    );

endmodule

// File: rtl/ldi_checker.sv
module ldi_checker (
    input logic        clk,
    input logic        rst,
    input logic        oe,
    input logic        in_valid,
    input logic        in_line_start,
    input logic        in_field_start,
    input logic        out_valid,
    input logic        out_line_start,
    input logic [15:0] out_data
);

    logic [1:0] fields_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_seen <= 2'd0;
        end else if (in_valid && in_line_start && in_field_start && fields_seen != 2'd2) begin
            fields_seen <= fields_seen + 2'd1;
        end
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_line_start && out_data == 16'h0));

    // R8
    oe_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(oe) |-> (out_data == 16'h0));

    // R7
    unarmed_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (fields_seen < 2'd2) |-> !out_valid);

    // R10
    start_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_line_start |-> out_valid);

    // R1
    run_opens_line_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_line_start);

endmodule

bind line_doubler_interp ldi_checker u_ldi_checker (
    .clk            (clk),
    .rst            (rst),
    .oe             (oe),
    .in_valid       (in_valid),
    .in_line_start  (in_line_start),
    .in_field_start (in_field_start),
    .out_valid      (out_valid),
    .out_line_start (out_line_start),
    .out_data       (out_data)
);

// File: tb/test_line_doubler_interp.sv
module test_line_doubler_interp;

    localparam int NW = 4;
    localparam int MW = 6;
    localparam int WW = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_width_sel;
    logic        cfg_lines_525;
    logic        oe;
    logic        in_valid, in_line_start, in_field_start;
    logic [15:0] in_data;
    logic        out_valid, out_line_start;
    logic [15:0] out_data;

    always #2 clk = ~clk;

    line_doubler_interp #(.W_NARROW(NW), .W_MID(MW), .W_WIDE(WW)) i_line_doubler_interp (
        .clk            (clk),
        .rst            (rst),
        .cfg_width_sel  (cfg_width_sel),
        .cfg_lines_525  (cfg_lines_525),
        .oe             (oe),
        .in_valid       (in_valid),
        .in_line_start  (in_line_start),
        .in_field_start (in_field_start),
        .in_data        (in_data),
        .out_valid      (out_valid),
        .out_line_start (out_line_start),
        .out_data       (out_data)
    );

    typedef struct {
        int          stamp;
        logic [15:0] d;
        bit          ls;
        bit          dc;
        int          req;
    } exp_t;

    exp_t        q[$];
    int          cyc = 0;
    int          nchk = 0;
    int          nfail = 0;
    int          fcount = 0;
    int          nout = 0;
    bit          open_period = 0;
    bit          done = 0;
    logic [15:0] prev_line [WW];
    logic [15:0] cur_line [WW];
    int          prev_w = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string rname(input int r);
        return $sformatf("R%0d", r);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] gen(input int fid, input int ln, input int i);
        logic [7:0] y, c;
        case (fid % 3)
            0: begin
                y = 8'(ln * 37 + i * 11 + fid * 5);
                c = 8'(((ln * 53) ^ (i * 29)) + fid);
            end
            1: begin
                y = (ln % 2 == 1) ? 8'd0 : 8'd255;
                if (i % 2 == 1) c = (ln % 2 == 1) ? 8'd2 : 8'd1;
                else            c = (ln % 2 == 1) ? 8'd255 : 8'd254;
            end
            default: begin
                y = 8'(255 - i * 19 - ln * 3);
                c = 8'(i * 71 + ln * 13 + fid);
            end
        endcase
        return {y, c};
    endfunction

    function automatic logic [15:0] mean_ref(input logic [15:0] a, input logic [15:0] b);
        int y, c;
        y = (int'(a[15:8]) + int'(b[15:8]) + 1) / 2;
        c = (int'(a[7:0]) + int'(b[7:0]) + 1) / 2;
        return {8'(y), 8'(c)};
    endfunction

    // Monitor: cycle-stamped comparison of every output sample
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                nout++;
                if (q.size() == 0 || q[0].stamp != cyc) begin
                    // R7 before arming, R6 in field-opening period, else R1
                    check(1'b0, (fcount < 2) ? "R7" : (open_period ? "R6" : "R1"), 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (!e.dc) begin
                        check(out_data[15:8] == e.d[15:8], rname(e.req), out_data[15:8], e.d[15:8]);
                        // R4 for chroma of averaged samples
                        check(out_data[7:0] == e.d[7:0], rname(e.req == 3 ? 4 : e.req),
                              out_data[7:0], e.d[7:0]);
                    end
                    // R10
                    check(out_line_start == e.ls, "R10", out_line_start, e.ls);
                end
            end else begin
                check(out_line_start == 1'b0, "R10", out_line_start, 0);
                if (q.size() > 0 && q[0].stamp == cyc) begin
                    void'(q.pop_front());
                    check(1'b0, "R1", 0, 1);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 0; in_line_start = 0; in_field_start = 0; in_data = 16'h0;
        end
    endtask

    task automatic send_line(input bit is_fs, input int w, input int fid, input int ln);
        int  c0;
        bit  armed;
        exp_t e;
        for (int i = 0; i < w; i++) cur_line[i] = gen(fid, ln, i);
        @(negedge clk);
        in_valid = 1; in_line_start = 1; in_field_start = is_fs; in_data = cur_line[0];
        c0 = cyc + 1;
        if (is_fs) fcount++;
        open_period = is_fs;
        armed = (fcount >= 2);
        if (armed) begin
            for (int j = 0; j < w; j++) begin
                e.stamp = c0 + 1 + j;
                e.d     = oe ? prev_line[j] : 16'h0;
                e.ls    = (j == 0);
                e.dc    = (j >= prev_w);
                e.req   = (j == w - 1) ? 5 : 2;  // R2, last sample R5
                q.push_back(e);
            end
            if (!is_fs) begin
                for (int j = 0; j < w; j++) begin
                    e.stamp = c0 + 1 + w + j;
                    e.d     = oe ? mean_ref(prev_line[j], cur_line[j]) : 16'h0;
                    e.ls    = (j == 0);
                    e.dc    = (j >= prev_w);
                    e.req   = oe ? 3 : 8;    // R3 averages, R8 blanking
                    q.push_back(e);
                end
            end
        end
        @(negedge clk);
        in_valid = 0; in_line_start = 0; in_field_start = 0;
        for (int i = 1; i < w; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = cur_line[i];
            @(negedge clk);
            in_valid = 0;
        end
        for (int i = 0; i < w; i++) prev_line[i] = cur_line[i];
        prev_w = w;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1 watchdog", 0, 1);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int sel_tab [6] = '{0, 0, 1, 2, 3, 1};
        int l525_tab[6] = '{1, 0, 1, 0, 1, 0};
        int w_tab   [6] = '{NW, MW, MW, WW, WW, MW};
        int fid = 0;
        rst = 1; oe = 1; cfg_width_sel = 2'd0; cfg_lines_525 = 1'b1;
        in_valid = 0; in_line_start = 0; in_field_start = 0; in_data = 16'h0;
        for (int i = 0; i < WW; i++) prev_line[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R9
        check(out_valid == 0, "R9", out_valid, 0);
        check(out_line_start == 0, "R9", out_line_start, 0);
        check(out_data == 16'h0, "R9", out_data, 0);
        rst = 0;
        @(negedge clk);
        check(out_valid == 0 && out_data == 16'h0, "R9", out_data, 0);

        for (int p = 0; p < 6; p++) begin
            for (int f = 0; f < 3; f++) begin
                idle(4);
                cfg_width_sel = 2'(sel_tab[p]);
                cfg_lines_525 = l525_tab[p][0];
                oe = (p == 4) ? 1'b0 : 1'b1;
                for (int ln = 0; ln < 3; ln++) begin
                    send_line(ln == 0, w_tab[p], fid, ln);
                    if (ln == 1) idle(3);
                end
                if (p == 0 && f == 0) begin
                    idle(2 * NW + 4);
                    // R7: nothing emitted during the first field
                    check(nout == 0, "R7", nout, 0);
                end
                fid++;
            end
        end
        idle(4 * WW + 8);
        check(q.size() == 0, "R1", q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule